// File: doc/BRIEF.md
# Two-Resource Explicit Rate Engine

This block computes, once per control period, an allowed input rate for each flow entering a router in which packets compete for two shared resources: processing cycles and output-link bytes. A start strobe hands it one sample of the processing-queue length and one of the transmit-queue length. It first steps a common rate for the flows that the router currently limits. The step is a proportional-integral correction on the total queue length, and both gains are divided by the number of such flows. It then gives each flow a blend of two candidate rates. One is the common rate, which shares link bytes equally. The other is a rate inversely proportional to the flow's processing density, which shares processing cycles equally. The weights come from how full the transmit queue is relative to the target.

All rates are counted per control period. The intended period is 240000 clock cycles, and the surrounding logic issues the strobe. One shared iterative divider serves every division. The flows are handled in two passes: the first builds the sum of reciprocal densities and the second produces the per-flow rates. At the end of the second pass the block publishes the new rates together with a one-cycle done flag. It also records which flows are limited by the router rather than by their own peak rate, and that set is used in the next period.

Top module: `er_engine`

## Requirements
- R1: A start pulse is accepted only while the engine is idle. Start asserted during a computation is ignored. Each accepted start yields exactly one `done` pulse, one cycle wide.
- R2: The common rate is updated as follows. With qs = q_proc + q_tx, qh = the qs of the previous accepted start (0 after reset), G = 20972·(qs − qh) + 3277·(qs − QTGT), and n = the number of flows in the bottleneck set (taken as 1 when the set is empty), the step is floor(floor(|G| / 65536) / n). The step is subtracted from the previous common rate when G ≥ 0 and added to it when G < 0.
- R3: The common rate saturates: it never goes below 0 and never exceeds 2^RATE_W − 1.
- R4: The processing-fair rate of flow i is floor(inv_i · n · r / H). Here inv_i = floor(65536 / x_i), a density x_i of 0 counts as 1, H is the sum of inv_j over the bottleneck set, and the result is limited to 2^RATE_W − 1. If H = 0, the processing-fair rate equals r.
- R5: Flow i receives floor(((QTGT − b)·pf_i + b·r) / QTGT), where b = min(q_tx, QTGT). The result always lies between pf_i and r.
- R6: When q_tx ≥ QTGT, every flow receives exactly the common rate.
- R7: When q_tx = 0, every flow receives exactly its processing-fair rate, so flows with lower density receive more.
- R8: After each computation, flow i is in the bottleneck set for the next period exactly when its new rate is ≤ its peak rate. After reset every flow is in the set.
- R9: The `rate` and `common_rate` outputs change only in the cycle in which `done` is high, and hold their values at all other times.
- R10: After reset, every `rate` is 0, `done` is 0 and `common_rate` equals R_INIT.
- R11: A start asserted in the same cycle as `done` is accepted and begins the next computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one control-period computation |
| q_proc | input | Q_W | Processing-queue length sample |
| q_tx | input | Q_W | Transmit-queue length sample |
| density | input | NFLOW·DEN_W | Per-flow processing density in cycles per byte, flow 0 in the low bits; hold stable until done |
| peak | input | NFLOW·RATE_W | Per-flow peak rate per period, flow 0 in the low bits; hold stable until done |
| rate | output | NFLOW·RATE_W | Per-flow allowed rate, flow 0 in the low bits |
| common_rate | output | RATE_W | Common rate of the bottleneck flows |
| done | output | 1 | One-cycle pulse when new rates are published |

## Verification
Two things can land on the same clock edge. The first is the publication of one period's rates. The second is the acceptance of the next period's start strobe. The bench raises start in the exact cycle where `done` is seen and checks both the rates just published and the rates that follow from the second sample. A separate case holds start high while the engine is busy and requires a single `done` pulse, and a single step of the common rate, for that one request.

// File: rtl/er_pkg.sv
package er_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP,
    ST_INV,
    ST_PF_GO,
    ST_PF,
    ST_BLEND
  } er_state_t;
endpackage

// File: rtl/er_divider.sv
module er_divider #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W:0]    rem_sh;
  logic [W-1:0]  q;
  logic [W-1:0]  dvs;
  logic [W-1:0]  nml;
  logic [CW-1:0] cnt;
  logic          busy;

  assign rem_sh = {rem[W-1:0], q[W-1]};
  assign quo    = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      q    <= '0;
      dvs  <= '0;
      nml  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        q    <= num;
        nml  <= num;
        dvs  <= den;
        rem  <= '0;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        if (rem_sh >= {1'b0, dvs}) begin
          rem <= rem_sh - {1'b0, dvs};
          q   <= {q[W-2:0], 1'b1};
        end else begin
          rem <= rem_sh;
          q   <= {q[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // quotient and remainder reproduce the latched dividend (R2, R4, R5 arithmetic)
  p_div_exact_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (((2*W)'(q) * (2*W)'(dvs) + (2*W)'(rem[W-1:0])) == (2*W)'(nml)) &&
             (rem < {1'b0, dvs}));

endmodule

// File: rtl/er_pi_term.sv
module er_pi_term #(
  parameter int QW     = 17,
  parameter int W      = 48,
  parameter int FRAC   = 16,
  parameter int GAIN_A = 20972,
  parameter int GAIN_B = 3277,
  parameter int QTGT   = 4096
) (
  input  logic [QW-1:0] qsum,
  input  logic [QW-1:0] qprev,
  output logic [W-1:0]  mag,
  output logic          neg
);
  logic signed [W-1:0] d_trend;
  logic signed [W-1:0] d_level;
  logic signed [W-1:0] acc;
  logic signed [W-1:0] absval;

  always_comb begin
    d_trend = $signed(W'(qsum)) - $signed(W'(qprev));
    d_level = $signed(W'(qsum)) - $signed(W'(QTGT));
    acc     = d_trend * $signed(W'(GAIN_A)) + d_level * $signed(W'(GAIN_B));
    neg     = acc[W-1];
    absval  = neg ? -acc : acc;
    mag     = $unsigned(absval) >> FRAC;
  end
endmodule

// File: rtl/er_engine.sv
module er_engine
  import er_pkg::*;
#(
  parameter int NFLOW  = 4,
  parameter int RATE_W = 24,
  parameter int Q_W    = 16,
  parameter int DEN_W  = 8,
  parameter int FRAC   = 16,
  parameter int GAIN_A = 20972,
  parameter int GAIN_B = 3277,
  parameter int QTGT   = 4096,
  parameter int R_INIT = 1000,
  parameter int DIV_W  = 48
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [Q_W-1:0]          q_proc,
  input  logic [Q_W-1:0]          q_tx,
  input  logic [NFLOW*DEN_W-1:0]  density,
  input  logic [NFLOW*RATE_W-1:0] peak,
  output logic [NFLOW*RATE_W-1:0] rate,
  output logic [RATE_W-1:0]       common_rate,
  output logic                    done
);
  localparam int IDX_W = (NFLOW > 1) ? $clog2(NFLOW) : 1;
  localparam int CNT_W = $clog2(NFLOW + 1);
  localparam int INV_W = FRAC + 1;
  localparam int HS_W  = INV_W + CNT_W;
  localparam logic [IDX_W-1:0]  LAST = IDX_W'(NFLOW - 1);
  localparam logic [RATE_W-1:0] RMAX = '1;
  localparam logic [Q_W-1:0]    QT_V = Q_W'(QTGT);

  er_state_t state;

  logic [IDX_W-1:0]  idx;
  logic [RATE_W-1:0] r_prev;
  logic [Q_W:0]      q_hist;
  logic [Q_W:0]      qsum_l;
  logic [Q_W-1:0]    qb_l;
  logic [CNT_W-1:0]  nq_l;
  logic              neg_l;
  logic [NFLOW-1:0]  mask;
  logic [NFLOW-1:0]  mask_nx;
  logic [INV_W-1:0]  inv   [NFLOW];
  logic [RATE_W-1:0] work  [NFLOW];
  logic [HS_W-1:0]   hsum;
  logic [RATE_W-1:0] pf_l;

  logic              div_go;
  logic [DIV_W-1:0]  div_num;
  logic [DIV_W-1:0]  div_den;
  logic [DIV_W-1:0]  div_quo;
  logic              div_done;

  logic [DEN_W-1:0]  dens_eff [NFLOW];
  logic [RATE_W-1:0] peak_a   [NFLOW];
  logic [CNT_W-1:0]  nq_c;
  logic [Q_W:0]      qsum_c;
  logic [DIV_W-1:0]  pi_mag;
  logic              pi_neg;
  logic [RATE_W-1:0] r_new_c;
  logic [HS_W-1:0]   hsum_nx;
  logic [RATE_W-1:0] quo_sat;
  logic [RATE_W-1:0] lo_c;
  logic [RATE_W-1:0] hi_c;

  for (genvar g = 0; g < NFLOW; g++) begin : g_unpack
    assign dens_eff[g] = (density[g*DEN_W +: DEN_W] == '0) ? DEN_W'(1)
                                                           : density[g*DEN_W +: DEN_W];
    assign peak_a[g]   = peak[g*RATE_W +: RATE_W];
  end

  always_comb begin
    logic [CNT_W-1:0] c;
    c = '0;
    for (int j = 0; j < NFLOW; j++) c = c + CNT_W'(mask[j]);
    nq_c = (c == '0) ? CNT_W'(1) : c;
  end

  assign qsum_c = {1'b0, q_proc} + {1'b0, q_tx};

  er_pi_term #(
    .QW(Q_W + 1), .W(DIV_W), .FRAC(FRAC),
    .GAIN_A(GAIN_A), .GAIN_B(GAIN_B), .QTGT(QTGT)
  ) u_pi (
    .qsum (qsum_c),
    .qprev(q_hist),
    .mag  (pi_mag),
    .neg  (pi_neg)
  );

  er_divider #(.W(DIV_W)) u_div (
    .clk (clk),
    .rst (rst),
    .go  (div_go),
    .num (div_num),
    .den (div_den),
    .quo (div_quo),
    .done(div_done)
  );

  always_comb begin
    logic [DIV_W-1:0] up;
    up = DIV_W'(r_prev) + div_quo;
    if (neg_l)
      r_new_c = (up > DIV_W'(RMAX)) ? RMAX : up[RATE_W-1:0];
    else
      r_new_c = (div_quo > DIV_W'(r_prev)) ? '0 : r_prev - div_quo[RATE_W-1:0];
  end

  assign hsum_nx = hsum + (mask[idx] ? HS_W'(div_quo[INV_W-1:0]) : HS_W'(0));
  assign quo_sat = (div_quo > DIV_W'(RMAX)) ? RMAX : div_quo[RATE_W-1:0];
  assign lo_c    = (pf_l < r_prev) ? pf_l : r_prev;
  assign hi_c    = (pf_l < r_prev) ? r_prev : pf_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      idx         <= '0;
      r_prev      <= RATE_W'(R_INIT);
      q_hist      <= '0;
      qsum_l      <= '0;
      qb_l        <= '0;
      nq_l        <= CNT_W'(1);
      neg_l       <= 1'b0;
      mask        <= '1;
      mask_nx     <= '1;
      hsum        <= '0;
      pf_l        <= '0;
      div_go      <= 1'b0;
      div_num     <= '0;
      div_den     <= DIV_W'(1);
      rate        <= '0;
      common_rate <= RATE_W'(R_INIT);
      done        <= 1'b0;
      for (int j = 0; j < NFLOW; j++) begin
        inv[j]  <= '0;
        work[j] <= '0;
      end
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            qsum_l  <= qsum_c;
            qb_l    <= (q_tx > QT_V) ? QT_V : q_tx;
            nq_l    <= nq_c;
            neg_l   <= pi_neg;
            div_num <= pi_mag;
            div_den <= DIV_W'(nq_c);
            div_go  <= 1'b1;
            state   <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (div_done) begin
            r_prev  <= r_new_c;
            q_hist  <= qsum_l;
            idx     <= '0;
            hsum    <= '0;
            div_num <= DIV_W'(1) << FRAC;
            div_den <= DIV_W'(dens_eff[0]);
            div_go  <= 1'b1;
            state   <= ST_INV;
          end
        end
        ST_INV: begin
          if (div_done) begin
            inv[idx] <= div_quo[INV_W-1:0];
            hsum     <= hsum_nx;
            if (idx == LAST) begin
              idx   <= '0;
              state <= ST_PF_GO;
            end else begin
              idx     <= idx + 1'b1;
              div_num <= DIV_W'(1) << FRAC;
              div_den <= DIV_W'(dens_eff[idx + 1'b1]);
              div_go  <= 1'b1;
            end
          end
        end
        ST_PF_GO: begin
          if (hsum == '0) begin
            div_num <= DIV_W'(r_prev);
            div_den <= DIV_W'(1);
          end else begin
            div_num <= DIV_W'(inv[idx]) * DIV_W'(nq_l) * DIV_W'(r_prev);
            div_den <= DIV_W'(hsum);
          end
          div_go <= 1'b1;
          state  <= ST_PF;
        end
        ST_PF: begin
          if (div_done) begin
            pf_l    <= quo_sat;
            div_num <= DIV_W'(QT_V - qb_l) * DIV_W'(quo_sat) + DIV_W'(qb_l) * DIV_W'(r_prev);
            div_den <= DIV_W'(QT_V);
            div_go  <= 1'b1;
            state   <= ST_BLEND;
          end
        end
        ST_BLEND: begin
          if (div_done) begin
            work[idx]    <= quo_sat;
            mask_nx[idx] <= (quo_sat <= peak_a[idx]);
            if (idx == LAST) begin
              for (int j = 0; j < NFLOW; j++) begin
                if (IDX_W'(j) == idx) begin
                  rate[j*RATE_W +: RATE_W] <= quo_sat;
                  mask[j]                  <= (quo_sat <= peak_a[j]);
                end else begin
                  rate[j*RATE_W +: RATE_W] <= work[j];
                  mask[j]                  <= mask_nx[j];
                end
              end
              common_rate <= r_prev;
              done        <= 1'b1;
              state       <= ST_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_PF_GO;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // one-cycle completion pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // published values hold between completions
  p_rates_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(rate) && $stable(common_rate)));

  // blended rate stays between the two candidates
  p_blend_between_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BLEND && div_done) |-> (quo_sat >= lo_c && quo_sat <= hi_c));

  // a start while busy never reaches the divider launch for a new period
  p_busy_ignore_r1: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> (state != ST_STEP || $past(state) == ST_STEP));

endmodule

// File: tb/tb_er_engine.sv
`timescale 1ns/1ps
module tb_er_engine;
  localparam int NF   = 4;
  localparam int RW   = 24;
  localparam int QW   = 16;
  localparam int DW   = 8;
  localparam int QT   = 4096;
  localparam longint RMAXL = (64'd1 << RW) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [QW-1:0]     q_proc = '0;
  logic [QW-1:0]     q_tx = '0;
  logic [NF*DW-1:0]  density;
  logic [NF*RW-1:0]  peak;
  logic [NF*RW-1:0]  rate;
  logic [RW-1:0]     common_rate;
  logic              done;

  int     dens [NF];
  longint pk   [NF];
  int     checks = 0;
  int     errors = 0;
  int     cyc = 0;

  longint m_r;
  longint m_qh;
  bit     m_mask [NF];
  longint e_rate [NF];

  always #4 clk = ~clk;

  always_comb begin
    for (int j = 0; j < NF; j++) begin
      density[j*DW +: DW] = DW'(dens[j]);
      peak[j*RW +: RW]    = RW'(pk[j]);
    end
  end

  er_engine dut (
    .clk(clk), .rst(rst), .start(start), .q_proc(q_proc), .q_tx(q_tx),
    .density(density), .peak(peak), .rate(rate),
    .common_rate(common_rate), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // requirement arithmetic, written from R2..R8
  task automatic model_step(input longint qp, input longint qt);
    longint qs, g, mg, st, h, pf, b, res;
    longint inv [NF];
    int n;
    qs = qp + qt;
    n = 0;
    for (int j = 0; j < NF; j++) if (m_mask[j]) n++;
    if (n == 0) n = 1;
    g  = 20972 * (qs - m_qh) + 3277 * (qs - QT);
    mg = (g < 0) ? -g : g;
    st = (mg >>> 16) / n;
    if (g >= 0) m_r = (st > m_r) ? 0 : m_r - st;
    else        m_r = (m_r + st > RMAXL) ? RMAXL : m_r + st;
    m_qh = qs;
    h = 0;
    for (int j = 0; j < NF; j++) begin
      inv[j] = 65536 / ((dens[j] == 0) ? 1 : dens[j]);
      if (m_mask[j]) h += inv[j];
    end
    b = (qt > QT) ? QT : qt;
    for (int j = 0; j < NF; j++) begin
      pf = (h == 0) ? m_r : (inv[j] * n * m_r) / h;
      if (pf > RMAXL) pf = RMAXL;
      res = ((QT - b) * pf + b * m_r) / QT;
      if (res > RMAXL) res = RMAXL;
      e_rate[j] = res;
    end
    for (int j = 0; j < NF; j++) m_mask[j] = (e_rate[j] <= pk[j]);
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic compare(input string req);
    for (int j = 0; j < NF; j++)
      check(req, longint'(rate[j*RW +: RW]), e_rate[j]);
    check(req, longint'(common_rate), m_r);
  endtask

  task automatic run(input longint qp, input longint qt, input string req);
    @(negedge clk);
    q_proc = QW'(qp);
    q_tx   = QW'(qt);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    wait_done();
    model_step(qp, qt);
    compare(req);
  endtask

  initial begin
    dens[0] = 1; dens[1] = 2; dens[2] = 4; dens[3] = 8;
    for (int j = 0; j < NF; j++) begin
      pk[j] = RMAXL;
      m_mask[j] = 1'b1;
    end
    m_r  = 1000;
    m_qh = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    check("R10 done", longint'(done), 0);
    check("R10 common", longint'(common_rate), 1000);
    for (int j = 0; j < NF; j++) check("R10 rate", longint'(rate[j*RW +: RW]), 0);

    // R6: transmit queue full, equal shares
    run(0, QT, "R6 R2");
    for (int j = 0; j < NF; j++) check("R6 equal", longint'(rate[j*RW +: RW]), longint'(common_rate));

    // R7: transmit queue empty, inverse-density shares
    run(QT, 0, "R7 R4");
    for (int j = 1; j < NF; j++)
      check("R7 order", longint'(rate[(j-1)*RW +: RW] >= rate[j*RW +: RW]), 1);

    // R5: sweep of the mix, plus transmit sample above target
    for (int s = 0; s <= 8; s++) run(QT - s * 512, s * 512, "R5 sweep");
    run(100, 6000, "R5 clamp");
    for (int j = 0; j < NF; j++) check("R6 above", longint'(rate[j*RW +: RW]), longint'(common_rate));

    // R3: drive the common rate to the floor, then recover
    for (int s = 0; s < 6; s++) run(60000, 5000, "R3 floor");
    check("R3 zero", longint'(common_rate), 0);
    for (int s = 0; s < 4; s++) run(0, 0, "R3 rise R2");

    // R8: a peak-limited flow leaves the bottleneck set
    pk[0] = 5;
    run(2000, 1000, "R8 first");
    run(2100, 900, "R8 second");
    run(1800, 0, "R8 third");
    pk[0] = RMAXL;
    run(2000, 2000, "R8 restore");

    // R4: zero density counts as one
    dens[3] = 0;
    run(3000, 500, "R4 zero density");
    dens[3] = 8;

    // R1 + R9: start held while busy gives one completion; outputs hold
    begin
      int pulses = 0;
      @(negedge clk);
      q_proc = QW'(1500); q_tx = QW'(1500);
      start = 1'b1;
      repeat (12) @(negedge clk);
      start = 1'b0;
      for (int t = 0; t < 1500; t++) begin
        if (done) pulses++;
        @(negedge clk);
      end
      check("R1 single done", pulses, 1);
      model_step(1500, 1500);
      compare("R1 R9 held start");
    end

    // R11: start in the done cycle is accepted
    @(negedge clk);
    q_proc = QW'(2500); q_tx = QW'(300);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    model_step(2500, 300);
    compare("R11 first");
    q_proc = QW'(500); q_tx = QW'(3500);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 done low", longint'(done), 0);
    wait_done();
    model_step(500, 3500);
    compare("R11 second");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule